// File: doc/BRIEF.md
# Memory-to-Stream Read DMA Engine

This engine copies a contiguous region of memory onto a stream output. A one-cycle start pulse captures four settings: a source byte address, a total byte count, a burst length cap and a beat size. The engine then walks the region with incrementing read bursts and issues one request at a time. Each returned read beat is passed straight to the stream. The stream's last-beat marker is raised on the final beat of the whole copy, and a one-cycle done pulse reports the return to idle.

Each burst is sized in two registered steps. The first step takes the nominal burst size and cuts it so that it stops at the next 4 KB line. The second step takes the smaller of that figure and the bytes still to be copied, and from the result derives the burst length field. A stop pulse sets an abort flag. The engine completes any burst the memory has already accepted, issues no further request and returns to idle. The next start clears the flag.

Top module: `mem_stream_reader`

## Requirements
- R1: While reset is asserted, arValid, rReady, tValid and done are all 0, whatever values the read data and stream inputs carry.
- R2: Every read request carries arBurst = 2'b01 (incrementing) and arSize equal to the captured beat size. arId, arLock, arCache, arProt, arQos and arUser are all zero.
- R3: The nominal burst holds (cfgMaxLen+1) << cfgBeatSize bytes. A burst that is not cut by the 4 KB line or by the remaining count has arLen = cfgMaxLen. No burst has arLen above cfgMaxLen.
- R4: A burst at address A whose nominal bytes plus A[11:0] reach 4096 is cut to 4096 − A[11:0] bytes. Its arLen is ceil(bytes / 2^size) − 1.
- R5: When fewer bytes remain than the 4 KB-limited burst size, the burst is cut to the remaining count, and arLen = ceil(remaining / 2^size) − 1.
- R6: The first request uses cfgSrcAddr. Each later request's address is the previous address plus that burst's byte count. All requests together cover exactly cfgByteCount bytes.
- R7: At most one burst is outstanding: no new request is raised before the last beat of the previous burst has been accepted. arAddr and arLen hold while arValid waits for arReady.
- R8: Accepted read beats appear on the stream in order. tData equals rData, tValid follows rValid and rReady follows tReady while a burst is being received.
- R9: tLast is 1 only on the last beat of the burst that exhausts the byte count.
- R10: done is a one-cycle pulse. It is high in the cycle after the last read beat of the final burst is accepted.
- R11: A start with cfgByteCount = 0 issues no request and pulses done two cycles after the start pulse.
- R12: A stop pulse lets the burst already accepted finish, issues no further request and leads to done. A stop pulse given while idle is cleared by the next start, which then runs to completion.
- R13: A start pulse while a transfer is in progress is ignored, and so are any setting changes made with it.
- R14: A read beat presented while the engine is not receiving a burst is not accepted: rReady and tValid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that captures the settings and begins a copy |
| stop | input | 1 | One-cycle pulse that requests an abort |
| cfgSrcAddr | input | ADDR_W | Source start byte address |
| cfgByteCount | input | CNT_W | Bytes to copy |
| cfgMaxLen | input | 8 | Burst length cap (beats minus one) |
| cfgBeatSize | input | 3 | Beat size as log2 of bytes |
| done | output | 1 | One-cycle pulse on return to idle |
| arId | output | ID_W | Read request ID (zero) |
| arAddr | output | ADDR_W | Read request address |
| arLen | output | 8 | Read request length (beats minus one) |
| arSize | output | 3 | Read request beat size |
| arBurst | output | 2 | Read request burst type (incrementing) |
| arLock | output | 1 | Read request lock (zero) |
| arCache | output | 4 | Read request cache attributes (zero) |
| arProt | output | 3 | Read request protection (zero) |
| arQos | output | 4 | Read request QoS (zero) |
| arUser | output | USER_W | Read request user bits (zero) |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request ready |
| rData | input | DATA_W | Read data |
| rLast | input | 1 | Last beat of a read burst |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |
| tData | output | DATA_W | Stream data |
| tLast | output | 1 | Last beat of the whole copy |
| tValid | output | 1 | Stream valid |
| tReady | input | 1 | Stream ready |

## Verification
The hardest case to create is the meeting of the two cuts. A burst has to reach a 4 KB line, and the count left over has to be smaller than the cut size. On top of that, the memory has to stall the request while read data is already waiting. The stimulus sweeps beat sizes 0 to 2 against length caps 0, 3, 15 and 255. It pairs each setting with start addresses just below a 4 KB line and with byte counts that are not multiples of the beat size. Meanwhile a memory model withholds arReady at random, and during those stalls it presents stray read beats.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIZE1,
    ST_SIZE2,
    ST_ADDR,
    ST_DATA
  } msrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture settings
    logic stage1;   // register 4 KB-limited size
    logic stage2;   // register final size and length
    logic arValid;  // request phase
    logic arFire;   // request accepted
    logic inData;   // receiving a burst
  } msrStrobe_t;

endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       stop,
  input  logic       arReady,
  input  logic       rValid,
  input  logic       rReady,
  input  logic       rLast,
  input  logic       pendZero,
  output msrStrobe_t strb,
  output logic       done
);

  msrState_e stateQ, stateD;
  logic      abortQ;
  logic      lastBeatFire;

  assign lastBeatFire = (stateQ == ST_DATA) && rValid && rReady && rLast;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (start) stateD = ST_SIZE1;
      ST_SIZE1: stateD = (abortQ || pendZero) ? ST_IDLE : ST_SIZE2;
      ST_SIZE2: stateD = ST_ADDR;
      ST_ADDR:  if (arReady) stateD = ST_DATA;
      ST_DATA:  if (lastBeatFire) stateD = (abortQ || pendZero) ? ST_IDLE : ST_SIZE1;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load    = start && (stateQ == ST_IDLE);
    strb.stage1  = (stateQ == ST_SIZE1);
    strb.stage2  = (stateQ == ST_SIZE2);
    strb.arValid = (stateQ == ST_ADDR);
    strb.arFire  = (stateQ == ST_ADDR) && arReady;
    strb.inData  = (stateQ == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      abortQ <= 1'b0;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stop)           abortQ <= 1'b1;
      else if (strb.load) abortQ <= 1'b0;
      done <= (stateQ != ST_IDLE) && (stateD == ST_IDLE);
    end
  end

  // R10: completion is reported for one cycle only
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: an abort seen before a request leads straight back to idle
  assert_abort_exit_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SIZE1 && abortQ) |=> (stateQ == ST_IDLE && done));

  // R13: a start while busy does not restart sizing from the address phase
  assert_busy_start_R13: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR && start && !arReady) |=> (stateQ == ST_ADDR));

endmodule

// File: rtl/msr_dpath.sv
module msr_dpath
  import msr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 32,
  parameter int LEN_W      = 8,
  parameter int SIZE_W     = 3,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  msrStrobe_t        strb,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [CNT_W-1:0]  cfgByteCount,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  logic [SIZE_W-1:0] cfgBeatSize,
  input  logic              arReady,
  input  logic              rValid,
  input  logic              rLast,
  input  logic              tReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [LEN_W-1:0]  arLen,
  output logic [SIZE_W-1:0] arSize,
  output logic              rReady,
  output logic              tValid,
  output logic              tLast,
  output logic              pendZero
);

  // widest nominal burst: (2^LEN_W) beats of 2^(2^SIZE_W - 1) bytes
  localparam int BYTE_W = LEN_W + 1 + (1 << SIZE_W) - 1;
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] srcAddr;
  logic [CNT_W-1:0]  pending;
  logic [LEN_W-1:0]  lenLimit;
  logic [SIZE_W-1:0] sizeReg;
  logic [BYTE_W-1:0] clip1;
  logic [BYTE_W-1:0] burstBytes;
  logic [LEN_W-1:0]  burstLen;
  logic              lastBurst;

  // stage one: nominal size, cut at the page line
  logic [BYTE_W-1:0] nominal;
  logic [BYTE_W-1:0] pageOff;
  logic [BYTE_W:0]   pageSum;
  logic              crossesPage;
  logic [BYTE_W-1:0] toEdge;
  logic [BYTE_W-1:0] clipNext;

  assign nominal     = BYTE_W'({1'b0, lenLimit} + 1'b1) << sizeReg;
  assign pageOff     = BYTE_W'(srcAddr[PAGE_W-1:0]);
  assign pageSum     = {1'b0, nominal} + {1'b0, pageOff};
  assign crossesPage = pageSum >= (BYTE_W+1)'(PAGE_BYTES);
  assign toEdge      = BYTE_W'(PAGE_BYTES) - pageOff;
  assign clipNext    = crossesPage ? toEdge : nominal;

  // stage two: cut to the remaining count, derive the length field
  logic [CNT_W-1:0]  clipWide;
  logic [BYTE_W-1:0] take;
  logic [BYTE_W-1:0] beatMask;
  logic [BYTE_W:0]   beats;
  logic [LEN_W-1:0]  newLen;

  assign clipWide = CNT_W'(clip1);
  assign take     = (pending < clipWide) ? pending[BYTE_W-1:0] : clip1;
  assign beatMask = ~({BYTE_W{1'b1}} << sizeReg);
  assign beats    = ({1'b0, take} + {1'b0, beatMask}) >> sizeReg;
  assign newLen   = (beats == '0) ? '0 : LEN_W'(beats - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr    <= '0;
      pending    <= '0;
      lenLimit   <= '0;
      sizeReg    <= '0;
      clip1      <= '0;
      burstBytes <= '0;
      burstLen   <= '0;
      lastBurst  <= 1'b0;
    end else begin
      if (strb.load) begin
        srcAddr   <= cfgSrcAddr;
        pending   <= cfgByteCount;
        lenLimit  <= cfgMaxLen;
        sizeReg   <= cfgBeatSize;
        lastBurst <= 1'b0;
      end
      if (strb.stage1) clip1 <= clipNext;
      if (strb.stage2) begin
        burstBytes <= take;
        burstLen   <= newLen;
      end
      if (strb.arFire) begin
        srcAddr   <= srcAddr + ADDR_W'(burstBytes);
        pending   <= pending - CNT_W'(burstBytes);
        lastBurst <= (pending == CNT_W'(burstBytes));
      end
    end
  end

  assign arAddr   = srcAddr;
  assign arLen    = burstLen;
  assign arSize   = sizeReg;
  assign pendZero = (pending == '0);

  // read beats pass to the stream only while a burst is being received
  assign rReady = strb.inData && tReady;
  assign tValid = strb.inData && rValid;
  assign tLast  = tValid && rLast && lastBurst;

  // R7: request fields hold while the request waits
  assert_ar_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.arValid && !arReady) |=> (strb.arValid && $stable(arAddr) && $stable(arLen)));

  // R4: no burst runs past the page line
  assert_page_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.arValid |-> (({1'b0, pageOff} + {1'b0, burstBytes}) <= (BYTE_W+1)'(PAGE_BYTES)));

  // R3: the length cap is never exceeded
  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.arValid |-> (arLen <= lenLimit));

  // R5: an accepted burst never exceeds the bytes still pending
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.arFire |-> (CNT_W'(burstBytes) <= pending && burstBytes != '0));

  // R9: the last-beat marker only appears once every byte is requested
  assert_tlast_final_R9: assert property (@(posedge clk) disable iff (!rstN)
    tLast |-> (pending == '0));

endmodule

// File: rtl/mem_stream_reader.sv
module mem_stream_reader
  import msr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int ID_W       = 4,
  parameter int USER_W     = 1,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [CNT_W-1:0]  cfgByteCount,
  input  logic [7:0]        cfgMaxLen,
  input  logic [2:0]        cfgBeatSize,
  output logic              done,
  output logic [ID_W-1:0]   arId,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic              arLock,
  output logic [3:0]        arCache,
  output logic [2:0]        arProt,
  output logic [3:0]        arQos,
  output logic [USER_W-1:0] arUser,
  output logic              arValid,
  input  logic              arReady,
  input  logic [DATA_W-1:0] rData,
  input  logic              rLast,
  input  logic              rValid,
  output logic              rReady,
  output logic [DATA_W-1:0] tData,
  output logic              tLast,
  output logic              tValid,
  input  logic              tReady
);

  msrStrobe_t strb;
  logic       pendZero;

  msr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stop     (stop),
    .arReady  (arReady),
    .rValid   (rValid),
    .rReady   (rReady),
    .rLast    (rLast),
    .pendZero (pendZero),
    .strb     (strb),
    .done     (done)
  );

  msr_dpath #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .LEN_W      (8),
    .SIZE_W     (3),
    .PAGE_BYTES (PAGE_BYTES)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgSrcAddr   (cfgSrcAddr),
    .cfgByteCount (cfgByteCount),
    .cfgMaxLen    (cfgMaxLen),
    .cfgBeatSize  (cfgBeatSize),
    .arReady      (arReady),
    .rValid       (rValid),
    .rLast        (rLast),
    .tReady       (tReady),
    .arAddr       (arAddr),
    .arLen        (arLen),
    .arSize       (arSize),
    .rReady       (rReady),
    .tValid       (tValid),
    .tLast        (tLast),
    .pendZero     (pendZero)
  );

  assign arValid = strb.arValid;
  assign arBurst = 2'b01;
  assign arId    = '0;
  assign arLock  = 1'b0;
  assign arCache = '0;
  assign arProt  = '0;
  assign arQos   = '0;
  assign arUser  = '0;
  assign tData   = rData;

endmodule

// File: tb/mem_stream_reader_tb_top.sv
module mem_stream_reader_tb_top;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;
  localparam int ID_W   = 4;
  localparam int USER_W = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              start = 1'b0, stop = 1'b0;
  logic [ADDR_W-1:0] cfgSrcAddr = '0;
  logic [CNT_W-1:0]  cfgByteCount = '0;
  logic [7:0]        cfgMaxLen = '0;
  logic [2:0]        cfgBeatSize = '0;
  logic              done;
  logic [ID_W-1:0]   arId;
  logic [ADDR_W-1:0] arAddr;
  logic [7:0]        arLen;
  logic [2:0]        arSize;
  logic [1:0]        arBurst;
  logic              arLock;
  logic [3:0]        arCache;
  logic [2:0]        arProt;
  logic [3:0]        arQos;
  logic [USER_W-1:0] arUser;
  logic              arValid;
  logic              arReady = 1'b0;
  logic [DATA_W-1:0] rData = '0;
  logic              rLast = 1'b0, rValid = 1'b0;
  logic              rReady;
  logic [DATA_W-1:0] tData;
  logic              tLast, tValid;
  logic              tReady = 1'b0;

  mem_stream_reader dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .cfgSrcAddr(cfgSrcAddr), .cfgByteCount(cfgByteCount),
    .cfgMaxLen(cfgMaxLen), .cfgBeatSize(cfgBeatSize), .done(done),
    .arId(arId), .arAddr(arAddr), .arLen(arLen), .arSize(arSize),
    .arBurst(arBurst), .arLock(arLock), .arCache(arCache), .arProt(arProt),
    .arQos(arQos), .arUser(arUser), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rLast(rLast), .rValid(rValid), .rReady(rReady),
    .tData(tData), .tLast(tLast), .tValid(tValid), .tReady(tReady)
  );

  int checks = 0;
  int fails  = 0;
  int resArCount;
  int resPend;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'hA5A5_5A5A;
  endfunction

  task automatic runXfer(input logic [31:0] a, input int cnt, input int len,
                         input int size, input int stopAt, input bit busyStart);
    int cyc;
    int expectDone;
    bit doneSeen = 0, prevRFire = 0, junk = 0, aborted = 0, busyHit = 0;
    int arCount = 0;
    logic [31:0] eAddr = a;
    int ePend = cnt;
    bit sBusy = 0;
    logic [31:0] sAddr = '0;
    int sLen = 0, sIdx = 0;
    logic [31:0] qAddr[$];
    bit qLast[$];

    @(negedge clk);
    cfgSrcAddr = a; cfgByteCount = cnt; cfgMaxLen = len[7:0]; cfgBeatSize = size[2:0];
    start = 1'b1;
    expectDone = (cnt == 0) ? 2 : -1;
    for (cyc = 1; cyc < 30000; cyc++) begin
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      if (doneSeen) begin
        chk(done == 1'b0, "R10", "done pulse width", done, 0);
        break;
      end
      if (done) begin
        chk(cyc == expectDone, "R10", "done cycle", cyc, expectDone);
        doneSeen = 1;
      end
      if (prevRFire || junk) rValid = 1'b0;
      junk = 0; prevRFire = 0;
      if (!rValid && sBusy && $urandom_range(0, 3) != 0) begin
        rValid = 1'b1;
        rData  = memWord(sAddr + (sIdx << size));
        rLast  = (sIdx == sLen);
      end
      arReady = ($urandom_range(0, 2) != 0);
      if (!rValid && !sBusy && arValid && !arReady) begin
        rValid = 1'b1; rData = 32'hBAD0_0000 + cyc; rLast = 1'($urandom_range(0, 1));
        junk = 1;
      end
      tReady = ($urandom_range(0, 3) != 0);
      if (busyStart && cyc == 7) begin
        start = 1'b1; cfgSrcAddr = 32'hDEAD_0000; cfgByteCount = 4; busyHit = 1;
      end
      #1;
      if (junk) chk(!rReady && !tValid, "R14", "stray beat taken", {rReady, tValid}, 0);
      if (arValid && arReady) begin
        int nom, off, lim, b, el;
        string tag;
        nom = (len + 1) << size;
        off = int'(eAddr & 32'hFFF);
        lim = (nom + off >= 4096) ? 4096 - off : nom;
        b   = (ePend < lim) ? ePend : lim;
        el  = ((b + (1 << size) - 1) >> size) - 1;
        tag = (ePend < lim) ? "R5" : ((lim < nom) ? "R4" : "R3");
        chk(!sBusy, "R7", "request while burst open", 1, 0);
        chk(arAddr == eAddr, busyHit ? "R13" : "R6", "request address", arAddr, eAddr);
        chk(int'(arLen) == el, tag, "request length", arLen, el);
        chk(int'(arSize) == size && arBurst == 2'b01 && arId == '0 && !arLock &&
            arCache == '0 && arProt == '0 && arQos == '0 && arUser == '0,
            "R2", "request fixed fields", {arSize, arBurst, arId}, {size[2:0], 2'b01, 4'h0});
        for (int i = 0; i <= el; i++) begin
          qAddr.push_back(eAddr + (i << size));
          qLast.push_back((ePend - b == 0) && (i == el));
        end
        eAddr = eAddr + b; ePend = ePend - b;
        sBusy = 1; sAddr = arAddr; sLen = int'(arLen); sIdx = 0;
        if (arCount == stopAt) begin stop = 1'b1; aborted = 1; end
        arCount++;
      end
      if (rValid && rReady) begin
        chk(tValid && tReady, "R8", "stream follows read beat", {tValid, tReady}, 3);
        if (qAddr.size() == 0) chk(0, "R8", "unexpected beat", 0, 1);
        else begin
          logic [31:0] ba;
          bit bl;
          ba = qAddr.pop_front(); bl = qLast.pop_front();
          chk(tData == memWord(ba), "R8", "stream data", tData, memWord(ba));
          chk(tLast == bl, "R9", "stream last marker", tLast, bl);
        end
        sIdx++; prevRFire = 1;
        if (rLast) begin
          sBusy = 0;
          if (ePend == 0 || aborted) expectDone = cyc + 1;
        end
      end else if (tValid && tReady) begin
        chk(0, "R8", "stream beat without read beat", 1, 0);
      end
    end
    if (cyc >= 30000) chk(0, "R10", "transfer never finished", cyc, expectDone);
    if (!aborted) chk(ePend == 0, "R6", "bytes covered", ePend, 0);
    else chk(arCount == stopAt + 1, "R12", "requests after stop", arCount, stopAt + 1);
    chk(qAddr.size() == 0, "R8", "beats missing", qAddr.size(), 0);
    if (cnt == 0) chk(arCount == 0, "R11", "request for empty copy", arCount, 0);
    rValid = 1'b0; arReady = 1'b0; rLast = 1'b0;
    resArCount = arCount; resPend = ePend;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] addrs[4];
    int cnts[4];
    int lens[4];
    addrs = '{32'h0000_0FF8, 32'h0000_1FFC, 32'h0000_2F00, 32'h0000_3000};
    cnts  = '{300, 9, 130, 1};
    lens  = '{0, 3, 15, 255};

    // R1: reset holds every output low even with live inputs
    rValid = 1'b1; tReady = 1'b1; arReady = 1'b1; rLast = 1'b1;
    repeat (3) @(negedge clk);
    chk(!arValid && !rReady && !tValid && !done, "R1", "outputs in reset",
        {arValid, rReady, tValid, done}, 0);
    rValid = 1'b0; tReady = 1'b0; arReady = 1'b0; rLast = 1'b0;
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!arValid && !done, "R1", "idle after reset", {arValid, done}, 0);

    // R11: empty copy
    runXfer(32'h0000_0100, 0, 3, 2, -1, 0);

    // R3 R4 R5 R6: sweep of beat size, length cap and page position
    for (int s = 0; s < 3; s++)
      for (int l = 0; l < 4; l++)
        for (int c = 0; c < 4; c++)
          runXfer(addrs[c], cnts[c], lens[l], s, -1, 0);

    // R12: stop during a transfer, including at the first burst
    runXfer(32'h0000_0FF8, 300, 3, 2, 1, 0);
    runXfer(32'h0000_0100, 64, 0, 2, 0, 0);

    // R12: stale stop in idle is cleared by the next start
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    runXfer(32'h0000_1FF0, 40, 7, 2, -1, 0);
    chk(resPend == 0 && resArCount == 2, "R12", "copy after idle stop", resArCount, 2);

    // R13: start while busy
    runXfer(32'h0000_0FE0, 200, 15, 2, -1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule